// File: doc/BRIEF.md
# Signed Adder-Subtractor with Status Flags

This block adds or subtracts two 4-bit two's-complement operands and reports the outcome with three status bits: a carry, a signed overflow and an odd/even indicator. A single select input chooses the operation. The arithmetic runs in a 5-bit word whose upper bit is held at zero on the operand side, so the extra bit carries the carry-out.

Subtraction feeds the second operand through bitwise inversion and injects a carry-in of one. The same ripple chain therefore serves both operations. Results that fall outside the signed range -8..7 wrap modulo 16 and are never saturated; the overflow bit marks them. The block is purely combinational. It has no clock or reset, and it is meant to sit inside a larger datapath that registers its outputs.

Top module: `addsub_flags`

## Requirements
- R1: The operands `a_i` and `b_i` are 4-bit two's-complement values. `sub_i` = 0 selects addition and `sub_i` = 1 selects subtraction (`a_i` minus `b_i`).
- R2: In add mode, `result_o` equals (`a_i` + `b_i`) modulo 16.
- R3: In subtract mode, `result_o` equals (`a_i` - `b_i`) modulo 16 and wraps without saturation. For example, 4 minus -5 gives 4'b1001, which reads -7.
- R4: In add mode, `carry_o` is 1 exactly when the unsigned sum of `a_i` and `b_i` exceeds 15.
- R5: In subtract mode, `carry_o` is bit 4 of the 5-bit sum `a_i` + (~`b_i`) + 1. It is therefore 1 exactly when `a_i` >= `b_i` read as unsigned values.
- R6: `overflow_o` is 1 exactly when the true signed sum or difference lies outside -8..7. For example, 6 + (-5) gives a result of 1 with `overflow_o` = 0.
- R7: `odd_o` equals bit 0 of `result_o`: it is 1 for an odd result and 0 for an even one.
- R8: All outputs depend only on the present inputs. They hold no state and need no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand, two's complement |
| b_i | input | 4 | Second operand, two's complement |
| sub_i | input | 1 | Operation select: 0 add, 1 subtract |
| result_o | output | 4 | Low four bits of the internal word |
| carry_o | output | 1 | Bit 4 of the internal word |
| overflow_o | output | 1 | Signed range violation |
| odd_o | output | 1 | Result is odd |

## Verification
The block holds no stored state, so the internal state that can go wrong is its wiring and logic: the carry chain, the operand inversion and the MSB that enters the overflow equation. Any such fault shows at the ports in the same evaluation as the input vector that exercises it. For example, a broken carry link corrupts `result_o` for every pair that propagates through it. Feeding the uninverted B MSB into the overflow XOR flips `overflow_o` for every subtraction. With only 512 possible input vectors, a sweep of all of them exposes every single-point fault, and directed spot values pin down the wrap and flag corner cases.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int unsigned OPW = 4;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;

  typedef struct packed {
    logic carry;
    logic ovf;
    logic odd;
  } flags_t;
endpackage

// File: rtl/addsub_operand.sv
// Conditions the second operand: passes it through or inverts it for subtraction.
module addsub_operand #(
  parameter int unsigned W = addsub_pkg::OPW
) (
  input  logic [W-1:0] b_i,
  input  addsub_pkg::op_e op_i,
  output logic [W-1:0] bm_o,
  output logic         cin_o
);
  logic inv;
  assign inv = (op_i == addsub_pkg::OP_SUB);

  for (genvar k = 0; k < W; k++) begin : g_inv
    assign bm_o[k] = b_i[k] ^ inv;
  end

  assign cin_o = inv;
endmodule

// File: rtl/addsub_ripple.sv
// Zero-extended ripple adder: word_o = {0,x} + {0,y} + cin.
module addsub_ripple #(
  parameter int unsigned W = addsub_pkg::OPW
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W:0]   word_o
);
  logic [W:0] c;
  assign c[0] = cin_i;

  for (genvar k = 0; k < W; k++) begin : g_fa
    logic p;
    assign p         = x_i[k] ^ y_i[k];
    assign word_o[k] = p ^ c[k];
    assign c[k+1]    = (x_i[k] & y_i[k]) | (p & c[k]);
  end

  assign word_o[W] = c[W];
endmodule

// File: rtl/addsub_flagger.sv
// Derives result and flags from the internal word.
module addsub_flagger #(
  parameter int unsigned W = addsub_pkg::OPW
) (
  input  logic               a_msb_i,
  input  logic               bm_msb_i,
  input  logic [W:0]         word_i,
  output logic [W-1:0]       result_o,
  output addsub_pkg::flags_t flags_o
);
  always_comb begin
    result_o      = word_i[W-1:0];
    flags_o.carry = word_i[W];
    // a ^ b' ^ s3 ^ c4 collapses to c4 ^ c3
    flags_o.ovf   = a_msb_i ^ bm_msb_i ^ word_i[W] ^ word_i[W-1];
    flags_o.odd   = word_i[0];
  end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int unsigned W = addsub_pkg::OPW
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         overflow_o,
  output logic         odd_o
);
  import addsub_pkg::*;

  op_e        op;
  logic [W-1:0] bm;
  logic         cin;
  logic [W:0]   word;
  flags_t       flags;

  assign op = op_e'(sub_i);

  addsub_operand #(.W(W)) u_operand (
    .b_i   (b_i),
    .op_i  (op),
    .bm_o  (bm),
    .cin_o (cin)
  );

  addsub_ripple #(.W(W)) u_ripple (
    .x_i    (a_i),
    .y_i    (bm),
    .cin_i  (cin),
    .word_o (word)
  );

  addsub_flagger #(.W(W)) u_flagger (
    .a_msb_i  (a_i[W-1]),
    .bm_msb_i (bm[W-1]),
    .word_i   (word),
    .result_o (result_o),
    .flags_o  (flags)
  );

  assign carry_o    = flags.carry;
  assign overflow_o = flags.ovf;
  assign odd_o      = flags.odd;
endmodule

// File: rtl/addsub_flags_chk.sv
module addsub_flags_chk #(
  parameter int unsigned W = addsub_pkg::OPW
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         sub_i,
  input logic [W-1:0] result_o,
  input logic         carry_o,
  input logic         overflow_o,
  input logic         odd_o
);
  logic [W-1:0]      ref_res;
  logic [W:0]        uadd;
  logic signed [W:0] ssum;
  logic              ref_ovf;

  always_comb begin
    ref_res = sub_i ? (a_i - b_i) : (a_i + b_i);
    uadd    = {1'b0, a_i} + {1'b0, b_i};
    ssum    = sub_i ? ({a_i[W-1], a_i} - {b_i[W-1], b_i})
                    : ({a_i[W-1], a_i} + {b_i[W-1], b_i});
    ref_ovf = ssum[W] != ssum[W-1];

    if (!sub_i) a_r2_add_result: assert (result_o == ref_res);
    if (sub_i)  a_r3_sub_result: assert (result_o == ref_res);
    if (!sub_i) a_r4_add_carry:  assert (carry_o == uadd[W]);
    if (sub_i)  a_r5_sub_carry:  assert (carry_o == (a_i >= b_i));
    a_r6_overflow: assert (overflow_o == ref_ovf);
    a_r7_odd:      assert (odd_o == (a_i[0] ^ b_i[0]));
  end
endmodule

bind addsub_flags addsub_flags_chk #(.W(W)) u_chk (
  .a_i        (a_i),
  .b_i        (b_i),
  .sub_i      (sub_i),
  .result_o   (result_o),
  .carry_o    (carry_o),
  .overflow_o (overflow_o),
  .odd_o      (odd_o)
);

// File: tb/sim_addsub_flags.sv
`timescale 1ns/1ps
module sim_addsub_flags;
  logic       clk;
  logic [3:0] a, b;
  logic       sub;
  logic [3:0] res;
  logic       carry, ovf, odd;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  addsub_flags u0 (
    .a_i(a), .b_i(b), .sub_i(sub),
    .result_o(res), .carry_o(carry), .overflow_o(ovf), .odd_o(odd)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d sub=%0d act=%0d exp=%0d", req, a, b, sub, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] av, input logic [3:0] bv, input logic sv);
    @(negedge clk);
    a = av; b = bv; sub = sv;
    #1;
  endtask

  // Reference model from the requirements
  task automatic check_model();
    int sa, sb, s, ua, ub;
    logic [3:0] er;
    sa = $signed(a); sb = $signed(b);
    ua = int'(a);    ub = int'(b);
    s  = sub ? sa - sb : sa + sb;
    er = s[3:0];
    chk(sub ? "R3 result" : "R2 result", int'(res), int'(er));
    if (sub) chk("R5 carry", int'(carry), int'(ua >= ub));
    else     chk("R4 carry", int'(carry), int'(ua + ub > 15));
    chk("R6 overflow", int'(ovf), int'(s < -8 || s > 7));
    chk("R7 odd", int'(odd), int'(er[0]));
  endtask

  task automatic t_idle();
    apply(4'd0, 4'd0, 1'b0);
    chk("R8 zero inputs result", int'(res), 0);
    chk("R8 zero inputs carry", int'(carry), 0);
    chk("R8 zero inputs ovf", int'(ovf), 0);
    chk("R7 zero inputs odd", int'(odd), 0);
  endtask

  task automatic t_spot();
    apply(4'd6, 4'b1011, 1'b0);           // 6 + (-5)
    chk("R6 6+-5 result", int'(res), 1);
    chk("R6 6+-5 ovf", int'(ovf), 0);
    chk("R4 6+-5 carry", int'(carry), 1);
    apply(4'd4, 4'b1011, 1'b1);           // 4 - (-5)
    chk("R3 4--5 wraps", int'(res), 4'b1001);
    chk("R6 4--5 ovf", int'(ovf), 1);
    chk("R5 4--5 carry", int'(carry), 0);
    apply(4'd7, 4'd1, 1'b0);              // 7 + 1
    chk("R2 7+1 wraps", int'(res), 4'b1000);
    chk("R6 7+1 ovf", int'(ovf), 1);
    apply(4'b1000, 4'd1, 1'b1);           // -8 - 1
    chk("R3 -8-1 wraps", int'(res), 4'b0111);
    chk("R6 -8-1 ovf", int'(ovf), 1);
    chk("R5 -8-1 carry", int'(carry), 1);
    apply(4'd3, 4'd3, 1'b1);              // equal operands
    chk("R5 3-3 carry", int'(carry), 1);
    chk("R7 3-3 odd", int'(odd), 0);
  endtask

  // R1, R8: every vector, one evaluation each
  task automatic t_sweep();
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++) begin
          apply(4'(i), 4'(j), 1'(s));
          check_model();
        end
  endtask

  initial begin
    a = '0; b = '0; sub = 1'b0;
    t_idle();
    t_spot();
    t_sweep();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule